// File: doc/BRIEF.md
# Burst Credit Ready Counter

This block keeps the flow-control credit for the sending side of a burst-oriented parallel channel. The far end grants permission for one burst at a time by sending a READY pulse. The sender reports each burst it finishes with a burst-complete pulse. The block counts both kinds of event in two free-running counters of `CNT_W` bits. The unanswered credit is the modulo difference between the two counters. A credit-available flag tells the sender's sequencer whether it may start another burst. A registered flow-on status gives the same information one cycle later, for software or slower logic.

A third register holds the burst counter value from before the most recent burst completion. The ready counter is compared against this register. When one more increment would carry the ready counter onto the current burst count, further READY pulses are dropped. This stops the credit difference from wrapping to zero, so at most 2^CNT_W − 1 READYs can be outstanding. Dropped pulses stay lost. Counting resumes once another burst completes and moves the register forward.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level or single-cycle pulse in one synchronous clock domain. Any READY that arrives from another clock domain must be synchronised outside the block.

Top module: `burst_credit_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, `ready_count` and `burst_count` become 0, `last_burst` becomes all ones (the burst count minus one), and `credit_avail` and `flow_on` are 0.
- R2: A high `ready_pulse` at a clock edge, when it is not blocked, raises `ready_count` by one in the cycle that follows. Otherwise `ready_count` holds.
- R3: A high `burst_done` at a clock edge raises `burst_count` by one, modulo 2^CNT_W, and loads `last_burst` with the value `burst_count` had before that edge. `burst_done` is never blocked.
- R4: `credit_avail` is 1 exactly when `ready_count` differs from `burst_count`. It follows the counter registers with no further delay.
- R5: `flow_on` is a register that shows, one cycle later, the value `credit_avail` had in the previous cycle. It is 0 in the first cycle after reset.
- R6: When `ready_count` − `burst_count` (modulo 2^CNT_W) already equals 2^CNT_W − 1, a `ready_pulse` is ignored and `ready_count` keeps its value.
- R7: After a `burst_done` lowers the outstanding credit below the maximum, the next `ready_pulse` is counted again.
- R8: When `ready_pulse` and `burst_done` arrive in the same cycle, both counters update at that edge. Whether the READY is dropped is decided from the counter values before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ready_pulse | input | 1 | One count per cycle held high: a READY from the far end |
| burst_done | input | 1 | One count per cycle held high: a burst has sent its last word |
| credit_avail | output | 1 | Ready and burst counts differ |
| flow_on | output | 1 | `credit_avail` delayed by one register |
| ready_count | output | CNT_W | Ready counter |
| burst_count | output | CNT_W | Burst counter |
| last_burst | output | CNT_W | Burst count saved before the latest completion |

## Verification
A ready counter that wraps shows up at once: the READY that should be dropped at full credit brings `credit_avail` down to 0 one cycle later. Pushing credit to the maximum therefore exposes an off-by-one in the inhibit compare within a single cycle. A stale or wrongly reset `last_burst` either drops a READY early or keeps READYs blocked after a burst completes. Both are visible in `ready_count` on the next edge. A flow-on register that is wired straight through or loses its reset shows a mismatch with the delayed `credit_avail` in the first cycle where the credit changes.

// File: rtl/credit_pkg.sv
package credit_pkg;
  localparam int unsigned DEF_CNT_W = 16;
endpackage

// File: rtl/ready_counter.sv
module ready_counter #(
  parameter int unsigned CNT_W = credit_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready_pulse,
  input  logic             inhibit,
  output logic [CNT_W-1:0] count
);
  logic step_en;
  assign step_en = ready_pulse && !inhibit;

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (step_en) count <= count + 1'b1;
  end

  // R2: an accepted READY moves the counter by exactly one
  p_ready_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ready_pulse && !inhibit) |=> count == CNT_W'($past(count) + 1'b1));

  // R6: an inhibited READY leaves the counter alone
  p_hold_when_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> count == $past(count));
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned CNT_W = credit_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             burst_done,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] prev_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      prev_count <= '1;
    end else if (burst_done) begin
      prev_count <= count;
      count      <= count + 1'b1;
    end
  end

  // R3: the saved value is the count from before the completion
  p_prev_saved_r3: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> prev_count == $past(count));

  // R3: without a completion both registers keep their values
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !burst_done |=> (count == $past(count)) && (prev_count == $past(prev_count)));
endmodule

// File: rtl/credit_compare.sv
module credit_compare #(
  parameter int unsigned CNT_W = credit_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ready_count,
  input  logic [CNT_W-1:0] burst_count,
  input  logic [CNT_W-1:0] last_burst,
  output logic             credit_avail,
  output logic             flow_on,
  output logic             inhibit
);
  assign credit_avail = (ready_count != burst_count);
  // ready_count == last_burst means ready_count + 1 == burst_count
  assign inhibit      = (ready_count == last_burst);

  always_ff @(posedge clk) begin
    if (rst) flow_on <= 1'b0;
    else     flow_on <= credit_avail;
  end

  // R5: the status register lags the live flag by one cycle
  p_flow_lag_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flow_on == $past(credit_avail));

  // R4: a blocked counter always means credit is present
  p_blocked_has_credit_r4: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> credit_avail);
endmodule

// File: rtl/burst_credit_tracker.sv
module burst_credit_tracker #(
  parameter int unsigned CNT_W = credit_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready_pulse,
  input  logic             burst_done,
  output logic             credit_avail,
  output logic             flow_on,
  output logic [CNT_W-1:0] ready_count,
  output logic [CNT_W-1:0] burst_count,
  output logic [CNT_W-1:0] last_burst
);
  localparam logic [CNT_W-1:0] MAX_GAP = '1;

  logic inhibit;

  ready_counter #(.CNT_W(CNT_W)) u_ready (
    .clk         (clk),
    .rst         (rst),
    .ready_pulse (ready_pulse),
    .inhibit     (inhibit),
    .count       (ready_count)
  );

  burst_counter #(.CNT_W(CNT_W)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .burst_done (burst_done),
    .count      (burst_count),
    .prev_count (last_burst)
  );

  credit_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk          (clk),
    .rst          (rst),
    .ready_count  (ready_count),
    .burst_count  (burst_count),
    .last_burst   (last_burst),
    .credit_avail (credit_avail),
    .flow_on      (flow_on),
    .inhibit      (inhibit)
  );

  logic [CNT_W-1:0] gap;
  assign gap = ready_count - burst_count;

  // R6: at full credit a lone READY cannot move the ready counter
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (ready_pulse && !burst_done && gap == MAX_GAP) |=> ready_count == $past(ready_count));

  // R6: the credit difference never wraps to zero through a READY
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (gap == MAX_GAP && !burst_done) |=> credit_avail);

  // R8: simultaneous events below the limit both take effect
  p_both_update_r8: assert property (@(posedge clk) disable iff (rst)
    (ready_pulse && burst_done && gap != MAX_GAP) |=>
      (ready_count == CNT_W'($past(ready_count) + 1'b1)) &&
      (burst_count == CNT_W'($past(burst_count) + 1'b1)));
endmodule

// File: tb/burst_credit_tracker_test.sv
module burst_credit_tracker_test;
  localparam int unsigned W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ready_pulse = 1'b0;
  logic burst_done = 1'b0;
  logic credit_avail, flow_on;
  logic [W-1:0] ready_count, burst_count, last_burst;

  always #2 clk = ~clk;

  burst_credit_tracker #(.CNT_W(W)) uut (
    .clk          (clk),
    .rst          (rst),
    .ready_pulse  (ready_pulse),
    .burst_done   (burst_done),
    .credit_avail (credit_avail),
    .flow_on      (flow_on),
    .ready_count  (ready_count),
    .burst_count  (burst_count),
    .last_burst   (last_burst)
  );

  typedef struct {
    logic [W-1:0] rc;
    logic [W-1:0] bc;
    logic [W-1:0] lb;
    logic         credit;
    logic         flow;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [W-1:0] m_rc, m_bc, m_lb;

  task automatic step(input logic r, input logic d, input string tag);
    exp_t e;
    logic [W-1:0] gap;
    @(negedge clk);
    ready_pulse = r;
    burst_done  = d;
    gap = m_rc - m_bc;
    e.flow = (m_rc != m_bc);
    if (r && gap != {W{1'b1}}) m_rc = m_rc + 1'b1;
    if (d) begin
      m_lb = m_bc;
      m_bc = m_bc + 1'b1;
    end
    e.rc = m_rc;
    e.bc = m_bc;
    e.lb = m_lb;
    e.credit = (m_rc != m_bc);
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares after each edge, away from the edge itself
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ready_count !== e.rc || burst_count !== e.bc || last_burst !== e.lb ||
            credit_avail !== e.credit || flow_on !== e.flow) begin
          fails++;
          $display("FAIL %s: got rc=%h bc=%h lb=%h credit=%b flow=%b, expected rc=%h bc=%h lb=%h credit=%b flow=%b",
                   e.tag, ready_count, burst_count, last_burst, credit_avail, flow_on,
                   e.rc, e.bc, e.lb, e.credit, e.flow);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    m_rc = '0;
    m_bc = '0;
    m_lb = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (ready_count !== '0 || burst_count !== '0 || last_burst !== '1 ||
        credit_avail !== 1'b0 || flow_on !== 1'b0) begin
      fails++;
      $display("FAIL R1: got rc=%h bc=%h lb=%h credit=%b flow=%b, expected rc=0 bc=0 lb=ffff credit=0 flow=0",
               ready_count, burst_count, last_burst, credit_avail, flow_on);
    end
    rst = 1'b0;

    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b1, "R4");
    step(1'b1, 1'b0, "R4");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, "R8");
    // fill credit to the maximum
    for (int i = 0; i < 65535; i++) step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R6");
    step(1'b0, 1'b1, "R7");
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b1, "R8");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, "R5");
    @(negedge clk);
    ready_pulse = 1'b0;
    burst_done  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule